// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple request/acknowledge host port and a 64K x 16 dynamic RAM with extended data output. It splits each 16-bit host address into an 8-bit row and an 8-bit column. It multiplexes them onto one 8-bit address bus and sequences the row strobe, the two column strobes (one per byte lane), write enable and output enable. Every analog interval of the memory is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row is served as a page-mode column cycle without a new row activation. A request to a different row closes the row and precharges it first. An external close request also closes the row, and so does the row strobe approaching its maximum low time. Read data is captured at the end of the column strobe pulse, which is safe because the memory keeps the word valid until the next column strobe falls. Refresh scheduling, power-up sequencing and pad drivers live outside.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset all strobes (`ras_n`, `ucas_n`, `lcas_n`, `we_n`, `oe_n`) are high, `dq_oe` is low and `ack` is low.
- R2: The row address (`addr[15:8]`) is on `ma` when `ras_n` falls, and the column address (`addr[7:0]`) is on `ma` when a column strobe falls, so every written word reads back from the same location.
- R3: `be[1]` enables `ucas_n` and the upper byte (bits 15..8), and `be[0]` enables `lcas_n` and the lower byte (bits 7..0). A byte write leaves the other byte unchanged, and a read returns zero in a disabled lane.
- R4: Consecutive accesses to the open row cause no new fall of `ras_n`.
- R5: An access to another row closes the open row. `ras_n` stays high for more than `T_RP` cycles before it falls again.
- R6: On a write, `we_n` is low at least one cycle before the column strobe falls, and `dq_oe` is high while the strobe falls.
- R7: `oe_n` is low only during a read column pulse. While it is low, `we_n` is high and `dq_oe` is low. It is high during write pulses.
- R8: Read data is returned on `rdata` in the cycle `ack` is high and equals the last data written to that location.
- R9: `ack` is a single-cycle pulse. A request with `be = 2'b00` is answered by `ack` together with `err`, and no column strobe falls.
- R10: While `close_req` is high the row is closed within `T_RP + 4` cycles and no row is activated. A request made meanwhile waits and completes after `close_req` falls.
- R11: `ras_n` never stays low for more than `T_RAS_MAX` consecutive cycles. An idle open row is closed automatically before then.
- R12: A column strobe is only ever low while `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until `ack` |
| addr | input | 16 | Host word address, row in the upper byte |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| wdata | input | 16 | Write data |
| ack | output | 1 | Single-cycle completion pulse |
| err | output | 1 | Request rejected (no byte enabled), valid with `ack` |
| rdata | output | 16 | Read data, valid with `ack` |
| close_req | input | 1 | Request to close the open row and stay idle |
| ras_n | output | 1 | Row address strobe |
| ucas_n | output | 1 | Column strobe, upper byte |
| lcas_n | output | 1 | Column strobe, lower byte |
| we_n | output | 1 | Write enable |
| oe_n | output | 1 | Output enable |
| ma | output | 8 | Multiplexed row/column address |
| dq_out | output | 16 | Data to the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data from the memory |

## Verification
A wrong state or counter shows up within one access at the pins. A lost open-row record appears as an extra or missing row-strobe fall, counted per sweep. A wrong address phase lands data at the wrong location, which the next read-back sweep over the whole small address space exposes. A bad lane decode corrupts the neighbouring byte on the word read that follows. A timer fault appears as a too-short precharge or an overlong row strobe, flagged in the cycle it happens.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_OPEN,
    ST_COL_ACCESS,
    ST_CAS_PRECHARGE,
    ST_RAS_PRECHARGE
  } edo_state_t;
endpackage

// File: rtl/edo_req_decode.sv
module edo_req_decode #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [1:0]             be,
  input  logic [ROW_W-1:0]       open_row,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   hit,
  output logic                   illegal,
  output logic [DW-1:0]          lane_mask
);
  localparam int HALF = DW / 2;

  function automatic logic [ROW_W-1:0] row_part(input logic [ROW_W+COL_W-1:0] a);
    return a[ROW_W+COL_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_part(input logic [ROW_W+COL_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [DW-1:0] mask_of(input logic [1:0] b);
    return {{HALF{b[1]}}, {HALF{b[0]}}};
  endfunction

  assign row       = row_part(addr);
  assign col       = col_part(addr);
  assign hit       = (row == open_row);
  assign illegal   = (be == 2'b00);
  assign lane_mask = mask_of(be);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int T_RAS_MAX = 24000,
  parameter int GUARD     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_active,
  output logic near_limit
);
  localparam int LIMIT = T_RAS_MAX - GUARD;
  localparam int CW    = $clog2(T_RAS_MAX + 2);

  logic [CW-1:0] low_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cycles <= '0;
    end else if (!ras_active) begin
      low_cycles <= '0;
    end else if (low_cycles != CW'(T_RAS_MAX + 1)) begin
      low_cycles <= low_cycles + 1'b1;
    end
  end

  assign near_limit = (low_cycles >= CW'(LIMIT));
endmodule

// File: rtl/edo_pin_drv.sv
module edo_pin_drv
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int MA_W  = 8
) (
  input  edo_state_t       state,
  input  logic             busy,
  input  logic             cnt_zero,
  input  logic             cur_we,
  input  logic [1:0]       cur_be,
  input  logic [ROW_W-1:0] host_row,
  input  logic [ROW_W-1:0] open_row,
  input  logic [COL_W-1:0] cur_col,
  output logic             ras_n,
  output logic             ucas_n,
  output logic             lcas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic [MA_W-1:0]  ma
);
  logic row_low, cas_low, wr_phase, row_phase;

  assign row_low   = (state == ST_ROW_OPEN) || (state == ST_COL_ACCESS) ||
                     (state == ST_CAS_PRECHARGE);
  assign cas_low   = (state == ST_COL_ACCESS);
  assign row_phase = (state == ST_ROW_OPEN) && busy && !cnt_zero;
  assign wr_phase  = cur_we && (((state == ST_ROW_OPEN) && busy && cnt_zero) || cas_low);

  assign ras_n  = !row_low;
  assign ucas_n = !(cas_low && cur_be[1]);
  assign lcas_n = !(cas_low && cur_be[0]);
  assign we_n   = !wr_phase;
  assign dq_oe  = wr_phase;
  assign oe_n   = !(cas_low && !cur_we);

  always_comb begin
    if (state == ST_IDLE)  ma = MA_W'(host_row);
    else if (row_phase)    ma = MA_W'(open_row);
    else                   ma = MA_W'(cur_col);
  end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W     = 8,
  parameter int COL_W     = 8,
  parameter int DW        = 16,
  parameter int T_RCD     = 5,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RP      = 8,
  parameter int T_RAS_MAX = 24000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   we,
  input  logic [1:0]             be,
  input  logic [DW-1:0]          wdata,
  output logic                   ack,
  output logic                   err,
  output logic [DW-1:0]          rdata,
  input  logic                   close_req,
  output logic                   ras_n,
  output logic                   ucas_n,
  output logic                   lcas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ma,
  output logic [DW-1:0]          dq_out,
  output logic                   dq_oe,
  input  logic [DW-1:0]          dq_in
);
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int M1      = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2      = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int GUARD   = T_CAS + T_CP + 4;

  edo_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             cur_we;
  logic [1:0]       cur_be;
  logic [COL_W-1:0] cur_col;
  logic [DW-1:0]    cur_wdata;
  logic [DW-1:0]    cur_mask;
  logic [ROW_W-1:0] open_row;
  logic             ack_q, err_q;
  logic [DW-1:0]    rdata_q;

  logic [ROW_W-1:0] d_row;
  logic [COL_W-1:0] d_col;
  logic             d_hit, d_illegal;
  logic [DW-1:0]    d_mask;
  logic             near_limit;
  logic             take;
  logic             cnt_zero;

  edo_req_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_dec (
    .addr(addr), .be(be), .open_row(open_row),
    .row(d_row), .col(d_col), .hit(d_hit), .illegal(d_illegal), .lane_mask(d_mask)
  );

  edo_ras_guard #(.T_RAS_MAX(T_RAS_MAX), .GUARD(GUARD)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_active(!ras_n), .near_limit(near_limit)
  );

  edo_pin_drv #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_pins (
    .state(state), .busy(busy), .cnt_zero(cnt_zero), .cur_we(cur_we), .cur_be(cur_be),
    .host_row(d_row), .open_row(open_row), .cur_col(cur_col),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n),
    .dq_oe(dq_oe), .ma(ma)
  );

  assign take     = req && !ack_q;
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      cur_we    <= 1'b0;
      cur_be    <= 2'b00;
      cur_col   <= '0;
      cur_wdata <= '0;
      cur_mask  <= '0;
      open_row  <= '0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take && d_illegal) begin
            ack_q <= 1'b1;
            err_q <= 1'b1;
          end else if (take && !close_req) begin
            open_row  <= d_row;
            cur_col   <= d_col;
            cur_we    <= we;
            cur_be    <= be;
            cur_wdata <= wdata;
            cur_mask  <= d_mask;
            busy      <= 1'b1;
            cnt       <= CNT_W'(T_RCD);
            state     <= ST_ROW_OPEN;
          end
        end
        ST_ROW_OPEN: begin
          if (busy) begin
            if (!cnt_zero) cnt <= cnt - 1'b1;
            else begin
              cnt   <= CNT_W'(T_CAS - 1);
              state <= ST_COL_ACCESS;
            end
          end else if (close_req || near_limit) begin
            cnt   <= CNT_W'(T_RP - 1);
            state <= ST_RAS_PRECHARGE;
          end else if (take && d_illegal) begin
            ack_q <= 1'b1;
            err_q <= 1'b1;
          end else if (take && d_hit) begin
            cur_col   <= d_col;
            cur_we    <= we;
            cur_be    <= be;
            cur_wdata <= wdata;
            cur_mask  <= d_mask;
            busy      <= 1'b1;
            cnt       <= '0;
          end else if (take) begin
            cnt   <= CNT_W'(T_RP - 1);
            state <= ST_RAS_PRECHARGE;
          end
        end
        ST_COL_ACCESS: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            if (!cur_we) rdata_q <= dq_in & cur_mask;
            ack_q <= 1'b1;
            busy  <= 1'b0;
            cnt   <= CNT_W'(T_CP - 1);
            state <= ST_CAS_PRECHARGE;
          end
        end
        ST_CAS_PRECHARGE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else state <= ST_ROW_OPEN;
        end
        ST_RAS_PRECHARGE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ack    = ack_q;
  assign err    = err_q;
  assign rdata  = rdata_q;
  assign dq_out = cur_wdata;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int T_RP      = 8,
  parameter int T_RAS_MAX = 24000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ack,
  input logic err,
  input logic close_req
);
  localparam int HW = $clog2(T_RP + 3);
  localparam int LW = $clog2(T_RAS_MAX + 3);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= HW'(T_RP + 1);
      lo_cnt <= '0;
    end else begin
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt != HW'(T_RP + 2)) hi_cnt <= hi_cnt + 1'b1;
      if (ras_n) lo_cnt <= '0;
      else if (lo_cnt != LW'(T_RAS_MAX + 2)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_cas_in_ras_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucas_n || !lcas_n) |-> !ras_n);

  assert_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe));

  assert_early_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ucas_n) || $fell(lcas_n)) && !we_n) |-> ($past(!we_n) && dq_oe));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_err_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ack);

  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt > HW'(T_RP)));

  assert_ras_max_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= LW'(T_RAS_MAX));

  assert_close_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (close_req && ras_n) |=> ras_n);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .ack(ack), .err(err), .close_req(close_req)
);

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;
  localparam int P_RP   = 3;
  localparam int P_RMAX = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, close_req = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0]  be = 2'b00;
  logic ack, err, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, dq_out;
  logic [15:0] dq_in = '0;
  logic [7:0]  ma;

  int checks = 0, failures = 0;
  int ras_falls = 0, cas_falls = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edo_page_ctrl #(.T_RCD(3), .T_CAS(2), .T_CP(1), .T_RP(P_RP), .T_RAS_MAX(P_RMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .we(we), .be(be), .wdata(wdata),
    .ack(ack), .err(err), .rdata(rdata), .close_req(close_req),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n),
    .ma(ma), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: 16 rows x 16 columns, EDO hold until next strobe fall
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  logic [7:0]  m_row = '0;
  logic        p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1, p_we = 1'b1;

  task automatic lane_fall(input int l);
    int idx;
    idx = {m_row[3:0], ma[3:0]};
    cas_falls++;
    chk(ras_n == 1'b0, "R12 strobe inside row", ras_n, 0);
    if (!we_n) begin
      chk(p_we == 1'b0 && dq_oe, "R6 early write", {p_we, dq_oe}, 2'b01);
      chk(oe_n == 1'b1, "R7 oe high on write", oe_n, 1);
      mem[idx][l*8 +: 8] = dq_out[l*8 +: 8];
    end else begin
      chk(oe_n == 1'b0 && !dq_oe, "R7 oe on read", {oe_n, dq_oe}, 0);
      dq_in[l*8 +: 8] = mem[idx][l*8 +: 8];
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin m_row = ma; ras_falls++; end
      if (p_u && !ucas_n) lane_fall(1);
      if (p_l && !lcas_n) lane_fall(0);
    end
    p_ras = ras_n; p_u = ucas_n; p_l = lcas_n; p_we = we_n;
  end

  function automatic logic [15:0] pat(input int r, input int c, input int k);
    return 16'((r * 37 + c * 11 + k * 97) * 16'h0123 + 16'h5A5A);
  endfunction

  function automatic logic [15:0] mk(input int r, input int c);
    return 16'((r << 8) | c);
  endfunction

  task automatic access(input logic w, input logic [15:0] a, input logic [1:0] b,
                        input logic [15:0] d, output logic [15:0] rd, output logic e);
    int t;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    t = 0;
    do begin @(negedge clk); t++; end while (!ack && t < 400);
    chk(ack == 1'b1, "R9 ack arrives", ack, 1);
    rd = rdata; e = err;
    req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R9 ack single cycle", ack, 0);
  endtask

  task automatic wr(input int r, input int c, input logic [1:0] b, input logic [15:0] d);
    logic [15:0] rd; logic e;
    int idx;
    idx = r * 16 + c;
    access(1'b1, mk(r, c), b, d, rd, e);
    if (b[1]) shadow[idx][15:8] = d[15:8];
    if (b[0]) shadow[idx][7:0]  = d[7:0];
  endtask

  task automatic rd_chk(input int r, input int c, input logic [1:0] b, input string tag);
    logic [15:0] rd, exp; logic e;
    access(1'b0, mk(r, c), b, 16'h0, rd, e);
    exp = shadow[r * 16 + c] & {{8{b[1]}}, {8{b[0]}}};
    chk(rd == exp && !e, tag, rd, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ras_n, ucas_n, lcas_n, we_n, oe_n} == 5'b11111 && !dq_oe && !ack,
        "R1 reset state", {ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe, ack}, 7'b1111100);

    begin : sweep_write
      int rf0;
      rf0 = ras_falls;
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 16; c++) wr(r, c, 2'b11, pat(r, c, 0));
      chk(ras_falls - rf0 == 4, "R4 one activation per row", ras_falls - rf0, 4);
    end

    begin : sweep_read_miss
      int rf0;
      rf0 = ras_falls;
      for (int c = 0; c < 16; c++)
        for (int r = 0; r < 4; r++) rd_chk(r, c, 2'b11, "R2 R8 read back across rows");
      chk(ras_falls - rf0 == 64, "R5 reopen on every row miss", ras_falls - rf0, 64);
    end

    for (int c = 0; c < 16; c++) wr(1, c, 2'b10, pat(1, c, 1));
    for (int c = 0; c < 16; c += 2) wr(1, c, 2'b01, pat(1, c, 2));
    for (int c = 0; c < 16; c++) rd_chk(1, c, 2'b11, "R3 byte lane merge");
    for (int c = 0; c < 16; c += 5) rd_chk(1, c, 2'b01, "R3 lower lane read");
    for (int c = 1; c < 16; c += 5) rd_chk(1, c, 2'b10, "R3 upper lane read");

    begin : illegal_be
      logic [15:0] rd; logic e; int cf0;
      cf0 = cas_falls;
      access(1'b1, mk(0, 0), 2'b00, 16'hFFFF, rd, e);
      chk(e == 1'b1, "R9 err on empty byte enable", e, 1);
      chk(cas_falls == cf0, "R9 no strobe on rejected request", cas_falls, cf0);
      rd_chk(0, 0, 2'b11, "R9 rejected write leaves data");
    end

    begin : close_row
      int rf0, t; bit seen;
      wr(2, 5, 2'b11, 16'hC0DE);
      @(negedge clk); close_req = 1'b1;
      repeat (P_RP + 4) @(negedge clk);
      chk(ras_n == 1'b1, "R10 row closed on request", ras_n, 1);
      rf0 = ras_falls;
      req = 1'b1; we = 1'b0; addr = mk(2, 5); be = 2'b11;
      seen = 1'b0;
      repeat (20) begin @(negedge clk); if (ack) seen = 1'b1; end
      chk(!seen && ras_n && ras_falls == rf0, "R10 no activation while closed",
          {seen, ras_n}, 2'b01);
      close_req = 1'b0;
      t = 0;
      do begin @(negedge clk); t++; end while (!ack && t < 400);
      chk(ack && rdata == 16'hC0DE, "R10 held request completes", rdata, 16'hC0DE);
      req = 1'b0;
      @(negedge clk);
    end

    begin : ras_limit
      int lowc; bit rose;
      rd_chk(3, 3, 2'b11, "R11 open row before idle wait");
      lowc = 0; rose = 1'b0;
      for (int i = 0; i < 600 && !rose; i++) begin
        @(negedge clk);
        if (ras_n) rose = 1'b1; else lowc++;
      end
      chk(rose && lowc <= P_RMAX, "R11 idle row closed in time", lowc, P_RMAX);
      rd_chk(3, 3, 2'b11, "R11 access after forced close");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule